// File: doc/BRIEF.md
# Trap-Entry Previous-Mode Status Updater

This block keeps the previous-mode fields of a hypervisor-capable core's machine status word and hypervisor status word, and updates them in the cycle a trap is taken. A trap is signalled by a one-cycle pulse. With the pulse come the target level (machine or hypervisor-supervisor), the virtualization bit and privilege level in force before the trap, and a flag that says whether the trap is an access fault or page fault raised while translating a guest-physical address. On a trap into the hypervisor-supervisor level, the block records the old virtualization bit, the old privilege and the translation flag in the hypervisor fields. On a trap into the machine level, it records them in the machine fields. On every trap it clears the registered virtualization bit.

Both status words are presented on read ports at the bit positions that the rest of the control register file decodes. A simple write port lets the surrounding register file load the writable fields. Bits the block does not hold always read as zero. The `XLEN` parameter selects a 32-bit or 64-bit machine status word. In the 32-bit variant the machine-level previous-virtualization and translation-fault fields are not built.

Top module: `trap_status_upd`

## Requirements
- R1: After reset, `mstat_o`, `hstat_o` and `virt_o` are all zero.
- R2: A trap into the hypervisor level (`trap_i`=1, `trap_to_m_i`=0) sets hypervisor bit 7 to the `cur_virt_i` value seen with the pulse, and sets machine bit 8 to 1 if `cur_priv_i` was supervisor (2'b01) and to 0 if it was user (2'b00).
- R3: A trap into the hypervisor level sets hypervisor bit 6 to `gpa_fault_i`.
- R4: A trap into the machine level (`trap_to_m_i`=1) loads machine bits 12:11 with `cur_priv_i`. In the 64-bit variant it also loads machine bit 39 with `cur_virt_i`.
- R5: In the 64-bit variant, a trap into the machine level sets machine bit 38 to 1 when `gpa_fault_i` is 1 and clears it to 0 otherwise.
- R6: `virt_o` is 0 in the cycle after any trap. Without a trap it follows `cur_virt_i` one cycle later.
- R7: Held field positions. Hypervisor word: bit 0 (prior-privilege access enable), 6, 7, 8 and 9 (second-level previous privilege and virtualization). Machine word: 8, 12:11, 17 (modify-privilege), and 38 and 39 in the 64-bit variant.
- R8: Every bit of either word outside the positions listed in R7 reads zero, even after a write of all ones.
- R9: With `wr_en_i`=1 and no trap, `wr_sel_i`=0 loads the machine fields and `wr_sel_i`=1 loads the hypervisor fields from the same bit positions of `wr_data_i`, visible the next cycle.
- R10: A write presented in the same cycle as a trap is dropped. Only the trap updates are applied.
- R11: A trap into the machine level leaves `hstat_o` unchanged. A trap into the hypervisor level leaves machine bits 12:11, 17, 38 and 39 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | One-cycle trap-taken pulse |
| trap_to_m_i | input | 1 | 1: trap goes to machine level, 0: to hypervisor level |
| cur_virt_i | input | 1 | Virtualization bit before the trap |
| cur_priv_i | input | 2 | Privilege before the trap (00 user, 01 supervisor, 11 machine) |
| gpa_fault_i | input | 1 | Trap is an access or page fault from guest-physical translation |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 1 | Write target: 0 machine word, 1 hypervisor word |
| wr_data_i | input | XLEN | Write data at word bit positions |
| mstat_o | output | XLEN | Machine status read port |
| hstat_o | output | XLEN | Hypervisor status read port |
| virt_o | output | 1 | Registered virtualization bit |

## Verification
The properties assume that a trap into the hypervisor level never comes from machine privilege. They also assume that the translation flag is asserted only together with a trap pulse that matters for it. The bench respects the first assumption by drawing the prior privilege for hypervisor-level traps only from user and supervisor. Machine-level traps take any of user, supervisor or machine privilege. Random cycles mix traps, writes and idle cycles, and sometimes put a write in the same cycle as a trap, so that the write-drop rule is exercised as well.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'b00,
      PRIV_S   = 2'b01,
      PRIV_RSV = 2'b10,
      PRIV_M   = 2'b11
   } priv_e;

   // hypervisor word positions
   localparam int H_SPRV = 0;
   localparam int H_STL  = 6;
   localparam int H_SPV  = 7;
   localparam int H_SP2P = 8;
   localparam int H_SP2V = 9;

   // machine word positions
   localparam int M_SPP    = 8;
   localparam int M_MPP_LO = 11;
   localparam int M_MPP_HI = 12;
   localparam int M_MPRV   = 17;
   localparam int M_MTL    = 38;
   localparam int M_MPV    = 39;

   // smallest width that holds the virtualization fields
   localparam int EXT_MIN_XLEN = M_MPV + 1;

   typedef struct packed {
      logic sp2v;
      logic sp2p;
      logic spv;
      logic stl;
      logic sprv;
   } hyp_f_t;

   typedef struct packed {
      logic       mprv;
      logic [1:0] mpp;
      logic       spp;
   } mach_base_t;

endpackage

// File: rtl/tsu_trap_decode.sv
module tsu_trap_decode (
   input  logic trap_i,
   input  logic to_m_i,
   input  logic wr_en_i,
   input  logic wr_sel_i,
   output logic m_evt_o,
   output logic hs_evt_o,
   output logic m_wr_o,
   output logic h_wr_o
);
   // a trap wins over a write in the same cycle
   assign m_evt_o  = trap_i & to_m_i;
   assign hs_evt_o = trap_i & ~to_m_i;
   assign m_wr_o   = wr_en_i & ~trap_i & ~wr_sel_i;
   assign h_wr_o   = wr_en_i & ~trap_i & wr_sel_i;
endmodule

// File: rtl/tsu_hyp_reg.sv
module tsu_hyp_reg
   import tsu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt_i,
   input  logic            wr_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            prev_virt_i,
   input  logic            gpa_fault_i,
   output logic [XLEN-1:0] word_o
);
   hyp_f_t q;

   logic unused_wbits;
   assign unused_wbits = ^wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (evt_i) begin
         q.spv <= prev_virt_i;
         q.stl <= gpa_fault_i;
      end else if (wr_i) begin
         q.sprv <= wdata_i[H_SPRV];
         q.stl  <= wdata_i[H_STL];
         q.spv  <= wdata_i[H_SPV];
         q.sp2p <= wdata_i[H_SP2P];
         q.sp2v <= wdata_i[H_SP2V];
      end
   end

   always_comb begin
      word_o         = '0;
      word_o[H_SPRV] = q.sprv;
      word_o[H_STL]  = q.stl;
      word_o[H_SPV]  = q.spv;
      word_o[H_SP2P] = q.sp2p;
      word_o[H_SP2V] = q.sp2v;
   end
endmodule

// File: rtl/tsu_mach_reg.sv
module tsu_mach_reg
   import tsu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            m_evt_i,
   input  logic            hs_evt_i,
   input  logic            wr_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            prev_virt_i,
   input  logic [1:0]      prev_priv_i,
   input  logic            gpa_fault_i,
   output logic [XLEN-1:0] word_o
);
   localparam bit HAS_EXT = (XLEN >= EXT_MIN_XLEN);

   mach_base_t      base_q;
   logic [XLEN-1:0] base_bits;
   logic [XLEN-1:0] ext_bits;

   logic unused_wbits;
   assign unused_wbits = ^wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (m_evt_i) begin
         base_q.mpp <= prev_priv_i;
      end else if (hs_evt_i) begin
         base_q.spp <= (prev_priv_i == PRIV_S);
      end else if (wr_i) begin
         base_q.mprv <= wdata_i[M_MPRV];
         base_q.mpp  <= wdata_i[M_MPP_HI:M_MPP_LO];
         base_q.spp  <= wdata_i[M_SPP];
      end
   end

   always_comb begin
      base_bits                    = '0;
      base_bits[M_SPP]             = base_q.spp;
      base_bits[M_MPP_HI:M_MPP_LO] = base_q.mpp;
      base_bits[M_MPRV]            = base_q.mprv;
   end

   generate
      if (HAS_EXT) begin : g_ext
         logic mpv_q;
         logic mtl_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mpv_q <= 1'b0;
               mtl_q <= 1'b0;
            end else if (m_evt_i) begin
               mpv_q <= prev_virt_i;
               mtl_q <= gpa_fault_i;
            end else if (wr_i) begin
               mpv_q <= wdata_i[M_MPV];
               mtl_q <= wdata_i[M_MTL];
            end
         end
         always_comb begin
            ext_bits        = '0;
            ext_bits[M_MPV] = mpv_q;
            ext_bits[M_MTL] = mtl_q;
         end
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = prev_virt_i ^ gpa_fault_i;
         assign ext_bits   = '0;
      end
   endgenerate

   assign word_o = base_bits | ext_bits;
endmodule

// File: rtl/tsu_virt_reg.sv
module tsu_virt_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic trap_i,
   input  logic cur_virt_i,
   output logic virt_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      virt_o <= 1'b0;
      else if (trap_i) virt_o <= 1'b0;
      else             virt_o <= cur_virt_i;
   end
endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd #(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trap_i,
   input  logic            trap_to_m_i,
   input  logic            cur_virt_i,
   input  logic [1:0]      cur_priv_i,
   input  logic            gpa_fault_i,
   input  logic            wr_en_i,
   input  logic            wr_sel_i,
   input  logic [XLEN-1:0] wr_data_i,
   output logic [XLEN-1:0] mstat_o,
   output logic [XLEN-1:0] hstat_o,
   output logic            virt_o
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("trap_status_upd: XLEN must be 32 or 64");
      end
   endgenerate

   logic m_evt, hs_evt, m_wr, h_wr;

   tsu_trap_decode u_dec (
      .trap_i   (trap_i),
      .to_m_i   (trap_to_m_i),
      .wr_en_i  (wr_en_i),
      .wr_sel_i (wr_sel_i),
      .m_evt_o  (m_evt),
      .hs_evt_o (hs_evt),
      .m_wr_o   (m_wr),
      .h_wr_o   (h_wr)
   );

   tsu_hyp_reg #(.XLEN(XLEN)) u_hyp (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (hs_evt),
      .wr_i        (h_wr),
      .wdata_i     (wr_data_i),
      .prev_virt_i (cur_virt_i),
      .gpa_fault_i (gpa_fault_i),
      .word_o      (hstat_o)
   );

   tsu_mach_reg #(.XLEN(XLEN)) u_mach (
      .clk         (clk),
      .rst_n       (rst_n),
      .m_evt_i     (m_evt),
      .hs_evt_i    (hs_evt),
      .wr_i        (m_wr),
      .wdata_i     (wr_data_i),
      .prev_virt_i (cur_virt_i),
      .prev_priv_i (cur_priv_i),
      .gpa_fault_i (gpa_fault_i),
      .word_o      (mstat_o)
   );

   tsu_virt_reg u_virt (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_i     (trap_i),
      .cur_virt_i (cur_virt_i),
      .virt_o     (virt_o)
   );
endmodule

// File: rtl/trap_status_chk.sv
module trap_status_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trap_i,
   input logic            trap_to_m_i,
   input logic            cur_virt_i,
   input logic [1:0]      cur_priv_i,
   input logic            gpa_fault_i,
   input logic [XLEN-1:0] mstat_o,
   input logic [XLEN-1:0] hstat_o,
   input logic            virt_o
);
   localparam logic [XLEN-1:0] H_KEEP = XLEN'(64'h3C1);
   localparam logic [XLEN-1:0] M_KEEP = (XLEN == 64) ? XLEN'(64'h0000_00C0_0002_1900)
                                                     : XLEN'(64'h0002_1900);

   // R6
   virt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> !virt_o);

   // R2
   spv_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && !trap_to_m_i) |=> hstat_o[7] == $past(cur_virt_i));

   // R3
   stl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && !trap_to_m_i) |=> hstat_o[6] == $past(gpa_fault_i));

   // R4
   mpp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && trap_to_m_i) |=> mstat_o[12:11] == $past(cur_priv_i));

   // R11
   hyp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_i && trap_to_m_i) |=> hstat_o == $past(hstat_o));

   // R8
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((hstat_o & ~H_KEEP) == '0) && ((mstat_o & ~M_KEEP) == '0));

   generate
      if (XLEN == 64) begin : g_ext_chk
         // R5
         mtl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trap_i && trap_to_m_i) |=> mstat_o[38] == $past(gpa_fault_i));
         // R4
         mpv_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trap_i && trap_to_m_i) |=> mstat_o[39] == $past(cur_virt_i));
      end
   endgenerate
endmodule

bind trap_status_upd trap_status_chk #(.XLEN(XLEN)) u_tsu_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .trap_i      (trap_i),
   .trap_to_m_i (trap_to_m_i),
   .cur_virt_i  (cur_virt_i),
   .cur_priv_i  (cur_priv_i),
   .gpa_fault_i (gpa_fault_i),
   .mstat_o     (mstat_o),
   .hstat_o     (hstat_o),
   .virt_o      (virt_o)
);

// File: tb/tb_trap_status_upd.sv
`timescale 1ns/1ps
module tb_trap_status_upd;
   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            trap_i = 1'b0, trap_to_m_i = 1'b0, cur_virt_i = 1'b0;
   logic [1:0]      cur_priv_i = 2'b00;
   logic            gpa_fault_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
   logic [XLEN-1:0] wr_data_i = '0;
   logic [XLEN-1:0] mstat_o, hstat_o;
   logic            virt_o;

   always #2 clk = ~clk;

   trap_status_upd #(.XLEN(XLEN)) dut (.*);

   int total = 0;
   int bad = 0;

   // reference state
   logic m_mpv = 0, m_mtl = 0, m_mprv = 0, m_spp = 0;
   logic [1:0] m_mpp = 0;
   logic h_sprv = 0, h_stl = 0, h_spv = 0, h_sp2p = 0, h_sp2v = 0;
   logic v_ref = 0;

   typedef struct packed {
      logic [XLEN-1:0] m;
      logic [XLEN-1:0] h;
      logic            v;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   function automatic exp_t snap();
      exp_t e;
      e.m = '0; e.h = '0;
      e.m[8] = m_spp; e.m[12:11] = m_mpp; e.m[17] = m_mprv;
      e.m[38] = m_mtl; e.m[39] = m_mpv;
      e.h[0] = h_sprv; e.h[6] = h_stl; e.h[7] = h_spv;
      e.h[8] = h_sp2p; e.h[9] = h_sp2v;
      e.v = v_ref;
      return e;
   endfunction

   task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] expv,
                        input string what);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic op(input logic tr, input logic tom, input logic v, input logic [1:0] pr,
                     input logic g, input logic we, input logic ws,
                     input logic [XLEN-1:0] wd, input string tag);
      @(negedge clk);
      trap_i = tr; trap_to_m_i = tom; cur_virt_i = v; cur_priv_i = pr;
      gpa_fault_i = g; wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
      if (tr) begin
         if (tom) begin
            m_mpv = v; m_mtl = g; m_mpp = pr;
         end else begin
            h_spv = v; h_stl = g; m_spp = (pr == 2'b01);
         end
         v_ref = 1'b0;
      end else begin
         v_ref = v;
         if (we && !ws) begin
            m_mprv = wd[17]; m_mpp = wd[12:11]; m_spp = wd[8];
            m_mtl = wd[38]; m_mpv = wd[39];
         end else if (we && ws) begin
            h_sprv = wd[0]; h_stl = wd[6]; h_spv = wd[7];
            h_sp2p = wd[8]; h_sp2v = wd[9];
         end
      end
      exp_q.push_back(snap());
      tag_q.push_back(tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, mstat_o, e.m, "mstat");
            check(t, hstat_o, e.h, "hstat");
            check(t, {{(XLEN-1){1'b0}}, virt_o}, {{(XLEN-1){1'b0}}, e.v}, "virt");
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   localparam logic [XLEN-1:0] ONES = '1;

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1", mstat_o, '0, "mstat");
      check("R1", hstat_o, '0, "hstat");
      check("R1", {{(XLEN-1){1'b0}}, virt_o}, '0, "virt");
      @(negedge clk); rst_n = 1'b1;
      op(0, 0, 0, 2'b00, 0, 0, 0, '0, "R1");
      op(0, 0, 1, 2'b01, 0, 0, 0, '0, "R6");
      // trap into hypervisor level from guest supervisor with translation fault
      op(1, 0, 1, 2'b01, 1, 0, 0, '0, "R2_R3_R6");
      op(1, 0, 0, 2'b00, 0, 0, 0, '0, "R2_R3");
      // traps into machine level
      op(1, 1, 1, 2'b01, 1, 0, 0, '0, "R4_R5_R11");
      op(1, 1, 0, 2'b11, 0, 0, 0, '0, "R4_R5");
      op(1, 1, 1, 2'b00, 0, 0, 0, '0, "R5_R11");
      // writes of all ones
      op(0, 0, 0, 2'b00, 0, 1, 0, ONES, "R7_R8_R9");
      op(0, 0, 1, 2'b00, 0, 1, 1, ONES, "R7_R8_R9");
      // hypervisor-level trap leaves machine virtualization fields alone
      op(1, 0, 0, 2'b00, 0, 0, 0, '0, "R11");
      // write colliding with trap is dropped
      op(1, 1, 0, 2'b01, 0, 1, 1, '0, "R10");
      op(1, 0, 1, 2'b01, 1, 1, 0, '0, "R10");
      op(0, 0, 0, 2'b00, 0, 1, 1, XLEN'(64'h0000_0000_0000_0141), "R9");
      // random mix
      for (int i = 0; i < 200; i++) begin
         logic tr, tom, v, g, we, ws;
         logic [1:0] pr;
         logic [XLEN-1:0] wd;
         tr = ($urandom_range(0, 2) == 0);
         tom = $urandom_range(0, 1) == 1;
         v = $urandom_range(0, 1) == 1;
         g = $urandom_range(0, 1) == 1;
         we = $urandom_range(0, 1) == 1;
         ws = $urandom_range(0, 1) == 1;
         wd = {$urandom, $urandom};
         if (tr && !tom) pr = 2'($urandom_range(0, 1));
         else begin
            pr = 2'($urandom_range(0, 2));
            if (pr == 2'b10) pr = 2'b11;
         end
         op(tr, tom, v, pr, g, we, ws, wd, "R2_R4_R9_R10_rand");
      end
      @(negedge clk);
      trap_i = 0; wr_en_i = 0;
      while (exp_q.size() > 0) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule